// File: doc/BRIEF.md
# Multiplexed address/data bus controller

This block sits between an 8-bit processor core and its external memory pins. The processor hands it one transfer request: a 17-bit address, a read/write select and, for writes, a data byte. The block then runs one complete bus cycle on the pins and reports completion, with the read byte for reads. On the pin side, the low eight address bits and the data share a single 8-bit bus. A latch strobe tells an external register when that bus carries the low address. The nine upper address bits have their own outputs. Separate active-low read and write strobes mark the data phase.

The block runs on a clock at twice the oscillator rate, so each clock cycle is one half-phase of the oscillator. A bus cycle has four segments: a latch segment, an address-hold segment, a strobe segment and a tail segment. Their default lengths are 3, 1, 3 and 1 half-phases, which gives phases 0 to 7. A request is first taken into a one-deep holding slot. A request that arrives while a cycle is running waits in the slot and starts the moment the running cycle ends. The bidirectional bus is presented as separate output, input and output-enable signals, for a pad cell at chip level.

Top module: `mbc_ctrl`

## Requirements
- R1: While reset is active, and on the first clock edges after it is released, the latch strobe is low, both read and write strobes are high, the bus output enable is low and completion is low.
- R2: A cycle starts with the latch strobe high for phases 0 to 2. The bus drives address bits 7:0 with its enable high in phases 0 to 3, so the low address is held for one phase after the latch strobe falls.
- R3: Address bits 16:8 appear on the upper address outputs from phase 0 and stay unchanged until the latch strobe of the next cycle rises.
- R4: The selected strobe goes low in phase 4, one phase after the latch strobe falls, and stays low for exactly three phases (4 to 6).
- R5: On a read, the bus output enable is low from phase 4 through phase 7, and the write strobe stays high for the whole cycle.
- R6: On a read, the value on the bus input during phase 6 (the last low phase of the read strobe) is captured. Completion is high in phase 7 only, and the captured byte is on the read-data output at that time.
- R7: On a write, the bus drives the write byte with its enable high from phase 4 through phase 7, one phase past the rise of the write strobe, and the read strobe stays high for the whole cycle.
- R8: The read and write strobes are never low together, and neither is low while the latch strobe is high.
- R9: When the block is idle, a request sampled on one clock edge raises the latch strobe on the next clock edge. A request accepted during a running cycle starts its own cycle, with a new latch strobe, in the phase right after the running cycle's phase 7.
- R10: A request presented while an earlier request is still waiting in the slot, and that earlier request is not being launched on the same edge, is dropped: no bus cycle is ever run for it.
- R11: The read-data output keeps its value until the next read completes; a write cycle leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Half-phase clock, twice the oscillator rate |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cpu_req | input | 1 | Transfer request, sampled on each rising edge |
| cpu_wr | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 17 | Transfer address |
| cpu_wdata | input | 8 | Write byte |
| cpu_done | output | 1 | One-clock completion pulse (phase 7) |
| cpu_rdata | output | 8 | Last byte read |
| bus_ad_o | output | 8 | Shared bus output value (low address, then write data) |
| bus_ad_i | input | 8 | Shared bus input value |
| bus_ad_oe | output | 1 | Shared bus output enable |
| bus_a_hi | output | 9 | Upper address bits 16:8 |
| bus_ale | output | 1 | Address latch strobe, active high |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The cycle is tried with reads and writes at both ends of the address space: all-zero and all-one upper bits, and low bytes of 00, FF and mixed patterns. This shows that the upper and lower address fields are routed separately and that the bus switches from address to write data at the right phase. The read bytes include 00 and 8-bit patterns that differ from whatever was on the bus before the strobe. This shows the byte is taken in the last strobe phase and not earlier. A write between reads, and a directed case with a read followed at once by a write, check that the read data holds. That directed case also runs a third request while the slot is full, which tells the back-to-back launch apart from a dropped request.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  parameter int ADDR_W = 17;
  parameter int DATA_W = 8;
  localparam int HI_W  = ADDR_W - DATA_W;

  typedef struct packed {
    logic              wr;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
  } mbc_req_t;

  typedef enum logic [1:0] {
    SEG_LATCH  = 2'd0,
    SEG_HOLD   = 2'd1,
    SEG_STROBE = 2'd2,
    SEG_TAIL   = 2'd3
  } mbc_seg_e;
endpackage

// File: rtl/mbc_slot.sv
module mbc_slot
  import mbc_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     req_i,
  input  mbc_req_t req_data_i,
  input  logic     launch_i,
  output logic     pend_o,
  output mbc_req_t cur_nxt_o
);
  logic     pend_q, pend_d;
  logic     accept;
  mbc_req_t hold_q;
  mbc_req_t cur_q;

  // slot refills in the same edge it launches; otherwise a full slot drops
  always_comb begin
    accept = req_i && (!pend_q || launch_i);
    pend_d = pend_q;
    if (launch_i) pend_d = 1'b0;
    if (accept)   pend_d = 1'b1;
    cur_nxt_o = launch_i ? hold_q : cur_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      hold_q <= '0;
      cur_q  <= '0;
    end else begin
      pend_q <= pend_d;
      if (accept)   hold_q <= req_data_i;
      if (launch_i) cur_q  <= hold_q;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int LATCH_PH = 3,
  parameter int HOLD_PH  = 1,
  parameter int STB_PH   = 3,
  parameter int TAIL_PH  = 1
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pend_i,
  output logic     launch_o,
  output logic     act_nxt_o,
  output mbc_seg_e seg_nxt_o,
  output logic     capture_o,
  output logic     done_nxt_o
);
  localparam int MAX_A = (LATCH_PH > HOLD_PH) ? LATCH_PH : HOLD_PH;
  localparam int MAX_B = (STB_PH > TAIL_PH) ? STB_PH : TAIL_PH;
  localparam int MAXPH = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW    = $clog2(MAXPH + 1);
  localparam logic [CW-1:0] LATCH_LAST = CW'(LATCH_PH - 1);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_PH - 1);
  localparam logic [CW-1:0] STB_LAST   = CW'(STB_PH - 1);
  localparam logic [CW-1:0] TAIL_LAST  = CW'(TAIL_PH - 1);

  logic          act_q, act_d;
  mbc_seg_e      seg_q, seg_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] seg_last;
  logic          at_end;

  always_comb begin
    case (seg_q)
      SEG_LATCH:  seg_last = LATCH_LAST;
      SEG_HOLD:   seg_last = HOLD_LAST;
      SEG_STROBE: seg_last = STB_LAST;
      default:    seg_last = TAIL_LAST;
    endcase
  end

  always_comb begin
    at_end   = act_q && (seg_q == SEG_TAIL) && (cnt_q == TAIL_LAST);
    launch_o = pend_i && (!act_q || at_end);
    act_d    = act_q;
    seg_d    = seg_q;
    cnt_d    = cnt_q;
    if (launch_o) begin
      act_d = 1'b1;
      seg_d = SEG_LATCH;
      cnt_d = '0;
    end else if (act_q) begin
      if (at_end) begin
        act_d = 1'b0;
      end else if (cnt_q == seg_last) begin
        seg_d = mbc_seg_e'(seg_q + 2'd1);
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      seg_q <= SEG_TAIL;
      cnt_q <= '0;
    end else begin
      act_q <= act_d;
      seg_q <= seg_d;
      cnt_q <= cnt_d;
    end
  end

  assign act_nxt_o  = act_d;
  assign seg_nxt_o  = seg_d;
  assign capture_o  = act_q && (seg_q == SEG_STROBE) && (cnt_q == STB_LAST);
  assign done_nxt_o = act_d && (seg_d == SEG_TAIL) && (cnt_d == '0);
endmodule

// File: rtl/mbc_pins.sv
module mbc_pins
  import mbc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act_nxt_i,
  input  mbc_seg_e          seg_nxt_i,
  input  mbc_req_t          cur_nxt_i,
  input  logic              capture_i,
  input  logic              done_nxt_i,
  input  logic [DATA_W-1:0] ad_i,
  output logic [DATA_W-1:0] ad_o,
  output logic              ad_oe,
  output logic [HI_W-1:0]   a_hi,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [DATA_W-1:0] rdata,
  output logic              done
);
  logic              addr_seg;
  logic              strobe;
  logic              ale_d, rd_n_d, wr_n_d, oe_d;
  logic [DATA_W-1:0] out_d;
  logic              take_rd;

  always_comb begin
    addr_seg = (seg_nxt_i == SEG_LATCH) || (seg_nxt_i == SEG_HOLD);
    strobe   = act_nxt_i && (seg_nxt_i == SEG_STROBE);
    ale_d    = act_nxt_i && (seg_nxt_i == SEG_LATCH);
    rd_n_d   = !(strobe && !cur_nxt_i.wr);
    wr_n_d   = !(strobe && cur_nxt_i.wr);
    oe_d     = act_nxt_i && (addr_seg || cur_nxt_i.wr);
    out_d    = addr_seg ? cur_nxt_i.addr[DATA_W-1:0] : cur_nxt_i.wdata;
    take_rd  = capture_i && !cur_nxt_i.wr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale   <= 1'b0;
      rd_n  <= 1'b1;
      wr_n  <= 1'b1;
      ad_oe <= 1'b0;
      ad_o  <= '0;
      a_hi  <= '0;
      rdata <= '0;
      done  <= 1'b0;
    end else begin
      ale   <= ale_d;
      rd_n  <= rd_n_d;
      wr_n  <= wr_n_d;
      ad_oe <= oe_d;
      done  <= done_nxt_i;
      a_hi  <= cur_nxt_i.addr[ADDR_W-1:DATA_W];
      if (oe_d)    ad_o  <= out_d;
      if (take_rd) rdata <= ad_i;
    end
  end
endmodule

// File: rtl/mbc_ctrl.sv
module mbc_ctrl
  import mbc_pkg::*;
#(
  parameter int LATCH_PH = 3,
  parameter int HOLD_PH  = 1,
  parameter int STB_PH   = 3,
  parameter int TAIL_PH  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_wr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_done,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [DATA_W-1:0] bus_ad_o,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic              bus_ad_oe,
  output logic [HI_W-1:0]   bus_a_hi,
  output logic              bus_ale,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  logic     rst_meta, rst_n_sync;
  mbc_req_t req_data;
  mbc_req_t cur_nxt;
  logic     pend, launch, act_nxt, capture, done_nxt;
  mbc_seg_e seg_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_n_sync <= rst_meta;
    end
  end

  assign req_data = '{wr: cpu_wr, addr: cpu_addr, wdata: cpu_wdata};

  mbc_slot u_slot (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .req_i      (cpu_req),
    .req_data_i (req_data),
    .launch_i   (launch),
    .pend_o     (pend),
    .cur_nxt_o  (cur_nxt)
  );

  mbc_seq #(
    .LATCH_PH (LATCH_PH),
    .HOLD_PH  (HOLD_PH),
    .STB_PH   (STB_PH),
    .TAIL_PH  (TAIL_PH)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .pend_i     (pend),
    .launch_o   (launch),
    .act_nxt_o  (act_nxt),
    .seg_nxt_o  (seg_nxt),
    .capture_o  (capture),
    .done_nxt_o (done_nxt)
  );

  mbc_pins u_pins (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .act_nxt_i  (act_nxt),
    .seg_nxt_i  (seg_nxt),
    .cur_nxt_i  (cur_nxt),
    .capture_i  (capture),
    .done_nxt_i (done_nxt),
    .ad_i       (bus_ad_i),
    .ad_o       (bus_ad_o),
    .ad_oe      (bus_ad_oe),
    .a_hi       (bus_a_hi),
    .ale        (bus_ale),
    .rd_n       (bus_rd_n),
    .wr_n       (bus_wr_n),
    .rdata      (cpu_rdata),
    .done       (cpu_done)
  );
endmodule

// File: rtl/mbc_ctrl_chk.sv
module mbc_ctrl_chk
  import mbc_pkg::*;
#(
  parameter int LATCH_PH = 3,
  parameter int HOLD_PH  = 1,
  parameter int STB_PH   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_done,
  input logic [DATA_W-1:0] bus_ad_o,
  input logic              bus_ad_oe,
  input logic [HI_W-1:0]   bus_a_hi,
  input logic              bus_ale,
  input logic              bus_rd_n,
  input logic              bus_wr_n
);
  logic        stb_any;
  logic [15:0] ale_run, gap_run, stb_run;

  assign stb_any = !bus_rd_n || !bus_wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_run <= '0;
      gap_run <= '0;
      stb_run <= '0;
    end else begin
      ale_run <= bus_ale ? ((ale_run == 16'hFFFF) ? ale_run : ale_run + 16'd1) : 16'd0;
      stb_run <= stb_any ? ((stb_run == 16'hFFFF) ? stb_run : stb_run + 16'd1) : 16'd0;
      if (bus_ale || stb_any)    gap_run <= 16'd0;
      else if (gap_run != 16'hFFFF) gap_run <= gap_run + 16'd1;
    end
  end

  assert_latch_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_ale) |-> (ale_run == 16'(LATCH_PH)));

  assert_hi_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ale |-> $stable(bus_a_hi));

  assert_strobe_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stb_any) |-> (gap_run == 16'(HOLD_PH)));

  assert_strobe_width_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stb_any) |-> (stb_run == 16'(STB_PH)));

  assert_read_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd_n |-> !bus_ad_oe);

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |=> !cpu_done);

  assert_done_at_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_done |-> ($rose(bus_rd_n) || $rose(bus_wr_n)));

  assert_write_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_ad_oe);

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr_n) |-> (bus_ad_oe && $stable(bus_ad_o)));

  assert_no_overlap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(!bus_rd_n && !bus_wr_n) && !(bus_ale && stb_any));
endmodule

bind mbc_ctrl mbc_ctrl_chk #(
  .LATCH_PH (LATCH_PH),
  .HOLD_PH  (HOLD_PH),
  .STB_PH   (STB_PH)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_done  (cpu_done),
  .bus_ad_o  (bus_ad_o),
  .bus_ad_oe (bus_ad_oe),
  .bus_a_hi  (bus_a_hi),
  .bus_ale   (bus_ale),
  .bus_rd_n  (bus_rd_n),
  .bus_wr_n  (bus_wr_n)
);

// File: tb/mbc_ctrl_bench.sv
module mbc_ctrl_bench;
  logic        clk;
  logic        rst_n;
  logic        cpu_req;
  logic        cpu_wr;
  logic [16:0] cpu_addr;
  logic [7:0]  cpu_wdata;
  logic        cpu_done;
  logic [7:0]  cpu_rdata;
  logic [7:0]  bus_ad_o;
  logic [7:0]  bus_ad_i;
  logic        bus_ad_oe;
  logic [8:0]  bus_a_hi;
  logic        bus_ale;
  logic        bus_rd_n;
  logic        bus_wr_n;

  int checks = 0;
  int fails  = 0;
  logic [7:0] model_rdata;

  mbc_ctrl u_mbc_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_req   (cpu_req),
    .cpu_wr    (cpu_wr),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_done  (cpu_done),
    .cpu_rdata (cpu_rdata),
    .bus_ad_o  (bus_ad_o),
    .bus_ad_i  (bus_ad_i),
    .bus_ad_oe (bus_ad_oe),
    .bus_a_hi  (bus_a_hi),
    .bus_ale   (bus_ale),
    .bus_rd_n  (bus_rd_n),
    .bus_wr_n  (bus_wr_n)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {wr, addr[16:0], wdata, read byte}
  localparam int NV = 6;
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 17'h0_0040, 8'h00, 8'hC3},
    {1'b1, 17'h1_FFFF, 8'h5A, 8'h00},
    {1'b0, 17'h1_0080, 8'h00, 8'h00},
    {1'b1, 17'h0_0000, 8'hFF, 8'h00},
    {1'b0, 17'h0_FF01, 8'h00, 8'hA5},
    {1'b1, 17'h1_5A3C, 8'h81, 8'h00}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_phase(input int p, input logic wr, input logic [16:0] a,
                             input logic [7:0] wd, input logic [7:0] exp_rd);
    logic exp_oe;
    exp_oe = wr ? 1'b1 : (p < 4);
    chk($sformatf("R2 ale ph%0d", p), 32'(bus_ale), 32'(p < 3));
    chk($sformatf("R5/R7 oe ph%0d", p), 32'(bus_ad_oe), 32'(exp_oe));
    if (exp_oe)
      chk($sformatf("R2/R7 ad_o ph%0d", p), 32'(bus_ad_o), (p < 4) ? 32'(a[7:0]) : 32'(wd));
    chk($sformatf("R4/R5 rd_n ph%0d", p), 32'(bus_rd_n), 32'(!(!wr && p >= 4 && p <= 6)));
    chk($sformatf("R4/R7 wr_n ph%0d", p), 32'(bus_wr_n), 32'(!(wr && p >= 4 && p <= 6)));
    chk($sformatf("R3 a_hi ph%0d", p), 32'(bus_a_hi), 32'(a[16:8]));
    chk($sformatf("R6 done ph%0d", p), 32'(cpu_done), 32'(p == 7));
    if (p == 7) chk("R6/R11 rdata", 32'(cpu_rdata), 32'(exp_rd));
  endtask

  task automatic issue(input logic wr, input logic [16:0] a, input logic [7:0] wd);
    cpu_req = 1'b1; cpu_wr = wr; cpu_addr = a; cpu_wdata = wd;
    @(posedge clk);
    @(negedge clk);
    cpu_req = 1'b0;
    chk("R9 no ale before launch edge", 32'(bus_ale), 32'd0);
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cpu_req = 1'b0; cpu_wr = 1'b0; cpu_addr = '0; cpu_wdata = '0;
    bus_ad_i = 8'h3C; model_rdata = 8'h00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 ale", 32'(bus_ale), 32'd0);
    chk("R1 rd_n", 32'(bus_rd_n), 32'd1);
    chk("R1 wr_n", 32'(bus_wr_n), 32'd1);
    chk("R1 oe", 32'(bus_ad_oe), 32'd0);
    chk("R1 done", 32'(cpu_done), 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after release", 32'({bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe}), 32'b0110);

    // vector walk
    for (int v = 0; v < NV; v++) begin
      logic        wr;
      logic [16:0] a;
      logic [7:0]  wd, rv;
      {wr, a, wd, rv} = VEC[v];
      bus_ad_i = 8'h3C;
      issue(wr, a, wd);
      if (!wr) model_rdata = rv;
      for (int p = 0; p < 8; p++) begin
        @(negedge clk);
        check_phase(p, wr, a, wd, model_rdata);
        if (p == 4 && !wr) bus_ad_i = rv;
        if (p == 4 && wr)  bus_ad_i = 8'hE7;
      end
      @(negedge clk);
      chk("R6 done ends", 32'(cpu_done), 32'd0);
      chk("R11 rdata holds", 32'(cpu_rdata), 32'(model_rdata));
      chk("R3 a_hi idle hold", 32'(bus_a_hi), 32'(a[16:8]));
    end

    // directed: back-to-back launch and dropped third request
    bus_ad_i = 8'h11;
    issue(1'b0, 17'h1_2301, 8'h00);
    model_rdata = 8'h6E;
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      check_phase(p, 1'b0, 17'h1_2301, 8'h00, model_rdata);
      if (p == 1) begin cpu_req = 1'b1; cpu_wr = 1'b1; cpu_addr = 17'h0_4455; cpu_wdata = 8'h99; end
      if (p == 2) cpu_req = 1'b0;
      if (p == 3) begin cpu_req = 1'b1; cpu_wr = 1'b0; cpu_addr = 17'h1_FFFE; cpu_wdata = 8'h00; end
      if (p == 4) begin cpu_req = 1'b0; bus_ad_i = 8'h6E; end
    end
    // R9: waiting write starts right after phase 7
    for (int p = 0; p < 8; p++) begin
      @(negedge clk);
      check_phase(p, 1'b1, 17'h0_4455, 8'h99, model_rdata);
    end
    // R10: the third request never runs; R11: write left rdata alone
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R10 dropped request no ale", 32'(bus_ale), 32'd0);
      chk("R10 dropped request no rd", 32'(bus_rd_n), 32'd1);
      chk("R11 rdata after write", 32'(cpu_rdata), 32'h6E);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule